// File: doc/BRIEF.md
# HDLC Serial Frame Transmitter with Automatic Underrun Abort

This block turns bytes written by a host into a bit-synchronous HDLC line signal. It emits one line bit on every clock. The host pushes bytes into a small transmit queue, and each write can mark its byte as the last one of a message. The block wraps each message in opening and closing 0x7E flags. It inserts a zero after every run of five ones inside the frame. After the last byte it appends a 16-bit frame check sequence. Between messages the line carries back-to-back flags.

If the queue runs dry while a message is still open, the block cannot finish that frame. It aborts the frame on its own by sending eight ones, and then falls back to idle flags. Any leftover bytes of the broken message that arrive later are dropped, up to and including the byte that carries the end mark. The underrun is recorded in a sticky event bit, which the host clears with a read strobe. Two real-time flags report whether the queue is full or empty.

Top module: `hdlc_tx_abort`

## Requirements
- R1: While and right after reset, `tx_empty` is 1, `tx_full` is 0 and `udr_flag` is 0.
- R2: `tx_empty` is 1 exactly when the queue holds no bytes. `tx_full` is 1 exactly when it holds DEPTH bytes, and while it is 1 a write is not taken. After a write into an empty queue, `tx_empty` is 0 in the next cycle.
- R3: With no message pending, `tx_bit` repeats the flag 0x7E, least significant bit first (0,1,1,1,1,1,1,0). A frame begins only after a complete flag, and only if a byte is waiting at that moment.
- R4: Message bytes go out least significant bit first, in the order they were written. Consecutive messages share the flag that separates them.
- R5: The end-marked byte is followed by the FCS and then a closing flag. The FCS uses the reflected generator 0x8408 (x^16+x^12+x^5+1), starts from 0xFFFF, is complemented, and is sent least significant bit first. A receiver running the same CRC over data and FCS ends with residue 0xF0B8.
- R6: Inside a frame, a 0 is inserted after every five consecutive 1s of data or FCS, including at the end of the FCS. Flags and aborts carry no inserted zeros. Seven or more consecutive 1s appear only during an abort.
- R7: If a byte that is not end-marked finishes while the queue is empty, the very next line bits are eight 1s. Idle flags follow them.
- R8: After an abort, the queued bytes of the broken message, up to and including its end-marked byte, are discarded and never sent. The next message is framed normally.
- R9: `udr_flag` is 1 in the cycle the first abort bit appears on `tx_bit`. It stays 1 until the host reads it.
- R10: A read (`rd_evt`=1) returns the current `udr_flag` and clears the bit for the next cycle. A read in the very cycle the bit is set returns 1 and still leaves it cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe into the transmit queue |
| wr_data | input | 8 | Byte to queue |
| wr_eom | input | 1 | Marks the written byte as the last of its message |
| tx_full | output | 1 | Queue cannot accept a byte |
| tx_empty | output | 1 | Queue holds no bytes |
| rd_evt | input | 1 | Host read strobe for the underrun event |
| udr_flag | output | 1 | Sticky underrun event bit |
| tx_bit | output | 1 | Serial HDLC line output |

## Verification
The bench decodes the line with its own receiver, which hunts for flags, removes inserted zeros, checks the CRC residue and counts aborts. It targets messages made of 0xFF and 0x7E bytes, where a design that skipped zero insertion or forgot the stuff bit at the end of the FCS would produce false flags or bad CRCs. It starves the queue in the middle of a message and checks three things: the abort starts at once, the event bit lines up with the first abort bit, and the trailing bytes are flushed. A design that resumed the old message would show an extra, corrupt frame. A read aimed at the exact cycle the event is set catches a latch that either loses the event or keeps it after the read.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

   typedef enum logic [2:0] {
      S_FLAG,
      S_DATA,
      S_FCS,
      S_TAIL,
      S_ABORT
   } tx_state_e;

   localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
   localparam logic [15:0] CRC_SEED   = 16'hFFFF;
   localparam logic [15:0] CRC_GEN_RF = 16'h8408;

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
   parameter int DW    = 9,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          full,
   output logic          empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;
   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
   localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

   if (DEPTH < 2) begin : g_depth_bad
      $error("hdlc_tx_fifo: DEPTH must be at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CNT_FULL);
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wp_nx = wp + AW'(1);
      assign rp_nx = rp + AW'(1);
   end else begin : g_wrap_cmp
      assign wp_nx = (wp == PTR_LAST) ? '0 : wp + AW'(1);
      assign rp_nx = (rp == PTR_LAST) ? '0 : rp + AW'(1);
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
   parameter int          W    = 16,
   parameter logic [15:0] GEN  = hdlc_tx_pkg::CRC_GEN_RF,
   parameter logic [15:0] SEED = hdlc_tx_pkg::CRC_SEED
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] crc_nx
);
   if (W < 2 || W > 16) begin : g_w_bad
      $error("hdlc_tx_crc: W must lie in 2..16");
   end

   logic [W-1:0] crc_q;
   logic         fb;

   assign fb = crc_q[0] ^ din;

   for (genvar i = 0; i < W; i++) begin : g_tap
      if (i == W - 1) begin : g_top
         assign crc_nx[i] = fb & GEN[i];
      end else begin : g_mid
         assign crc_nx[i] = crc_q[i+1] ^ (fb & GEN[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     crc_q <= SEED[W-1:0];
      else if (init)  crc_q <= SEED[W-1:0];
      else if (en)    crc_q <= crc_nx;
   end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
   import hdlc_tx_pkg::*;
#(
   parameter int DW        = 8,
   parameter int CRC_W     = 16,
   parameter int ABORT_LEN = 8,
   parameter int STUFF_RUN = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             q_empty,
   input  logic [DW:0]      q_dout,
   output logic             q_pop,
   output logic             crc_init,
   output logic             crc_en,
   output logic             crc_bit,
   input  logic [CRC_W-1:0] crc_nx,
   output logic             tx_bit,
   output logic             ab_start,
   output logic             ab_on
);
   localparam int IDX_MAX = (CRC_W > ABORT_LEN) ? CRC_W : ABORT_LEN;
   localparam int IW      = $clog2(IDX_MAX);
   localparam int OW      = $clog2(STUFF_RUN + 1);
   localparam logic [IW-1:0] LAST_FLAG  = IW'(7);
   localparam logic [IW-1:0] LAST_DATA  = IW'(DW - 1);
   localparam logic [IW-1:0] LAST_FCS   = IW'(CRC_W - 1);
   localparam logic [IW-1:0] LAST_ABORT = IW'(ABORT_LEN - 1);
   localparam logic [OW-1:0] RUN_LIM    = OW'(STUFF_RUN);

   if (DW != 8) begin : g_dw_bad
      $error("hdlc_tx_framer: DW must be 8");
   end
   if (CRC_W < DW) begin : g_crc_bad
      $error("hdlc_tx_framer: CRC_W must not be below DW");
   end
   if (ABORT_LEN < 7) begin : g_abort_bad
      $error("hdlc_tx_framer: ABORT_LEN must be at least 7");
   end
   if (STUFF_RUN != 5) begin : g_run_bad
      $error("hdlc_tx_framer: STUFF_RUN must be 5");
   end

   tx_state_e        st;
   logic [IW-1:0]    idx;
   logic [OW-1:0]    ones;
   logic [CRC_W-1:0] sh;
   logic             cur_eom;
   logic             flush;

   logic             in_body, stuff, data_bit, bit_now;
   logic [OW-1:0]    ones_nx;
   logic             start, last_byte, last_fcs, need_next, underrun;
   logic             data_pop, flush_pop;

   assign in_body   = (st == S_DATA) || (st == S_FCS);
   assign stuff     = in_body && (ones == RUN_LIM);
   assign data_bit  = in_body && !stuff;

   always_comb begin
      if (data_bit)   ones_nx = sh[0] ? ones + OW'(1) : '0;
      else if (stuff) ones_nx = '0;
      else            ones_nx = ones;
   end

   always_comb begin
      case (st)
         S_FLAG:  bit_now = FLAG_BYTE[idx[2:0]];
         S_DATA,
         S_FCS:   bit_now = stuff ? 1'b0 : sh[0];
         S_ABORT: bit_now = 1'b1;
         default: bit_now = 1'b0;
      endcase
   end

   assign start     = (st == S_FLAG) && (idx == LAST_FLAG) && !q_empty && !flush;
   assign last_byte = (st == S_DATA) && data_bit && (idx == LAST_DATA);
   assign last_fcs  = (st == S_FCS) && data_bit && (idx == LAST_FCS);
   assign need_next = last_byte && !cur_eom;
   assign underrun  = need_next && q_empty;
   assign data_pop  = need_next && !q_empty;
   assign flush_pop = flush && !q_empty;
   assign q_pop     = start || data_pop || flush_pop;

   assign crc_init  = start;
   assign crc_en    = (st == S_DATA) && data_bit;
   assign crc_bit   = sh[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_FLAG;
         idx      <= '0;
         ones     <= '0;
         sh       <= '0;
         cur_eom  <= 1'b0;
         flush    <= 1'b0;
         tx_bit   <= 1'b0;
         ab_start <= 1'b0;
         ab_on    <= 1'b0;
      end else begin
         tx_bit   <= bit_now;
         ab_on    <= (st == S_ABORT);
         ab_start <= (st == S_ABORT) && (idx == '0);

         if (underrun)                      flush <= 1'b1;
         else if (flush_pop && q_dout[DW])  flush <= 1'b0;

         case (st)
            S_FLAG: begin
               if (idx == LAST_FLAG) begin
                  idx <= '0;
                  if (start) begin
                     st      <= S_DATA;
                     sh      <= {{(CRC_W-DW){1'b0}}, q_dout[DW-1:0]};
                     cur_eom <= q_dout[DW];
                     ones    <= '0;
                  end
               end else begin
                  idx <= idx + IW'(1);
               end
            end
            S_DATA: begin
               ones <= ones_nx;
               if (data_bit) begin
                  sh  <= sh >> 1;
                  idx <= idx + IW'(1);
                  if (last_byte) begin
                     idx <= '0;
                     if (cur_eom) begin
                        st <= S_FCS;
                        sh <= ~crc_nx;
                     end else if (q_empty) begin
                        st <= S_ABORT;
                     end else begin
                        sh      <= {{(CRC_W-DW){1'b0}}, q_dout[DW-1:0]};
                        cur_eom <= q_dout[DW];
                     end
                  end
               end
            end
            S_FCS: begin
               ones <= ones_nx;
               if (data_bit) begin
                  sh  <= sh >> 1;
                  idx <= idx + IW'(1);
                  if (last_fcs) begin
                     idx <= '0;
                     st  <= (ones_nx == RUN_LIM) ? S_TAIL : S_FLAG;
                  end
               end
            end
            S_TAIL: begin
               st  <= S_FLAG;
               idx <= '0;
            end
            S_ABORT: begin
               if (idx == LAST_ABORT) begin
                  st  <= S_FLAG;
                  idx <= '0;
               end else begin
                  idx <= idx + IW'(1);
               end
            end
            default: begin
               st  <= S_FLAG;
               idx <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/hdlc_tx_abort.sv
module hdlc_tx_abort #(
   parameter int DEPTH     = 16,
   parameter int ABORT_LEN = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       wr_eom,
   output logic       tx_full,
   output logic       tx_empty,
   input  logic       rd_evt,
   output logic       udr_flag,
   output logic       tx_bit
);
   localparam int DW    = 8;
   localparam int QW    = DW + 1;
   localparam int CRC_W = 16;

   logic [QW-1:0]    q_dout;
   logic             q_pop;
   logic             crc_init, crc_en, crc_bit;
   logic [CRC_W-1:0] crc_nx;
   logic             ab_start, ab_on;
   logic             udr_q;

   hdlc_tx_fifo #(.DW(QW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_en),
      .din   ({wr_eom, wr_data}),
      .pop   (q_pop),
      .dout  (q_dout),
      .full  (tx_full),
      .empty (tx_empty)
   );

   hdlc_tx_crc #(.W(CRC_W)) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (crc_init),
      .en     (crc_en),
      .din    (crc_bit),
      .crc_nx (crc_nx)
   );

   hdlc_tx_framer #(
      .DW        (DW),
      .CRC_W     (CRC_W),
      .ABORT_LEN (ABORT_LEN),
      .STUFF_RUN (5)
   ) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .q_empty  (tx_empty),
      .q_dout   (q_dout),
      .q_pop    (q_pop),
      .crc_init (crc_init),
      .crc_en   (crc_en),
      .crc_bit  (crc_bit),
      .crc_nx   (crc_nx),
      .tx_bit   (tx_bit),
      .ab_start (ab_start),
      .ab_on    (ab_on)
   );

   assign udr_flag = udr_q | ab_start;

   always_ff @(posedge clk) begin
      if (!rst_n)      udr_q <= 1'b0;
      else if (rd_evt) udr_q <= 1'b0;
      else             udr_q <= udr_flag;
   end
endmodule

// File: rtl/hdlc_tx_abort_chk.sv
module hdlc_tx_abort_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_full,
   input logic tx_empty,
   input logic rd_evt,
   input logic udr_flag,
   input logic udr_q,
   input logic tx_bit,
   input logic ab_start,
   input logic ab_on
);
   logic [3:0] run;

   always_ff @(posedge clk) begin
      if (!rst_n)      run <= '0;
      else if (tx_bit) run <= (run == 4'd15) ? run : run + 4'd1;
      else             run <= '0;
   end

   // R2
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_full && tx_empty));

   // R6
   long_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_bit && run >= 4'd6) |-> ab_on);

   // R7
   abort_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ab_on |-> tx_bit);

   // R9
   set_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ab_start |-> (udr_flag && tx_bit));

   // R9
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (udr_flag && !rd_evt) |=> udr_flag);

   // R10
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_evt |=> !udr_q);
endmodule

bind hdlc_tx_abort hdlc_tx_abort_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_full  (tx_full),
   .tx_empty (tx_empty),
   .rd_evt   (rd_evt),
   .udr_flag (udr_flag),
   .udr_q    (udr_q),
   .tx_bit   (tx_bit),
   .ab_start (ab_start),
   .ab_on    (ab_on)
);

// File: tb/hdlc_tx_abort_bench.sv
`timescale 1ns/1ps
module hdlc_tx_abort_bench;
   localparam int DEPTH = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_eom = 1'b0;
   logic       rd_evt = 1'b0;
   logic       tx_full, tx_empty, udr_flag, tx_bit;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   hdlc_tx_abort #(.DEPTH(DEPTH), .ABORT_LEN(8)) u_hdlc_tx_abort (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .wr_eom   (wr_eom),
      .tx_full  (tx_full),
      .tx_empty (tx_empty),
      .rd_evt   (rd_evt),
      .udr_flag (udr_flag),
      .tx_bit   (tx_bit)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
      return (c >> 1) ^ (((c[0] ^ b) != 1'b0) ? 16'h8408 : 16'h0000);
   endfunction

   function automatic logic [7:0] pick_byte();
      case ($urandom % 6)
         0: return 8'hFF;
         1: return 8'h7E;
         2: return 8'h3F;
         default: return 8'($urandom);
      endcase
   endfunction

   // expected frames
   logic [7:0] exp_bytes [$];
   int         exp_lens  [$];

   // line receiver
   bit rx_bits [0:2047];
   int rx_len = 0;
   int rx_ones = 0;
   bit rx_in = 1'b0;
   int n_frames = 0;
   int n_aborts = 0;
   int n_stuffs = 0;

   task automatic take_frame(input int flen);
      logic [15:0] c = 16'hFFFF;
      int          l;
      int          mism = 0;
      n_frames++;
      if (exp_lens.size() == 0) begin
         chk(1'b0, "R4", "unexpected frame bits", flen, 0);
         return;
      end
      l = exp_lens.pop_front();
      for (int k = 0; k < flen; k++) c = crc_step(c, rx_bits[k]);
      for (int k = 0; k < l; k++) begin
         logic [7:0] eb = exp_bytes.pop_front();
         logic [7:0] rb = '0;
         if ((k + 1) * 8 <= flen)
            for (int j = 0; j < 8; j++) rb[j] = rx_bits[k*8 + j];
         if (rb != eb) mism++;
      end
      chk(flen == (l + 2) * 8, "R4", "frame bit length", flen, (l + 2) * 8);
      chk(mism == 0, "R4", "mismatched bytes", mism, 0);
      chk(c == 16'hF0B8, "R5", "crc residue", c, 16'hF0B8);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_bit) begin
            rx_ones++;
            if (rx_ones == 7) begin
               n_aborts++;
               rx_in  = 1'b0;
               rx_len = 0;
            end
            if (rx_in && rx_len < 2048) begin
               rx_bits[rx_len] = 1'b1;
               rx_len++;
            end
         end else begin
            if (rx_in && rx_ones == 5) begin
               n_stuffs++;
            end else if (rx_ones == 6) begin
               if (rx_in && rx_len > 7) take_frame(rx_len - 7);
               rx_in  = 1'b1;
               rx_len = 0;
            end else if (rx_in && rx_len < 2048) begin
               rx_bits[rx_len] = 1'b0;
               rx_len++;
            end
            rx_ones = 0;
         end
      end
   end

   bit saw_full = 1'b0;

   task automatic put(input logic [7:0] b, input logic e);
      while (tx_full) begin
         saw_full = 1'b1;
         wr_en = 1'b0;
         @(negedge clk);
      end
      wr_en   = 1'b1;
      wr_data = b;
      wr_eom  = e;
      @(negedge clk);
      wr_en  = 1'b0;
      wr_eom = 1'b0;
   endtask

   task automatic send_msg(input int len);
      logic [7:0] b;
      exp_lens.push_back(len);
      for (int i = 0; i < len; i++) begin
         b = pick_byte();
         exp_bytes.push_back(b);
         put(b, (i == len - 1));
      end
   endtask

   task automatic wait_drain();
      int t = 0;
      while (exp_lens.size() != 0 && t < 30000) begin
         @(negedge clk);
         t++;
      end
      chk(exp_lens.size() == 0, "R4", "frames still missing", exp_lens.size(), 0);
      repeat (40) @(negedge clk);
   endtask

   task automatic wait_abort(output bit seen);
      int t = 0;
      seen = 1'b0;
      while (!udr_flag && t < 600) begin
         @(negedge clk);
         t++;
      end
      seen = udr_flag;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog all act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      bit ok;
      bit ln [0:31];
      int ab0, fr0, ones8;
      void'($urandom(32'd4242));

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(tx_empty == 1'b1, "R1", "empty in reset", tx_empty, 1);
      chk(tx_full == 1'b0, "R1", "full in reset", tx_full, 0);
      chk(udr_flag == 1'b0, "R1", "event in reset", udr_flag, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_empty == 1'b1 && udr_flag == 1'b0, "R1", "state after reset",
          {tx_empty, udr_flag}, 2);

      // R3: idle flag stream
      repeat (4) @(negedge clk);
      for (int i = 0; i < 32; i++) begin
         ln[i] = tx_bit;
         @(negedge clk);
      end
      ok = 1'b1;
      for (int i = 0; i < 24; i++) if (ln[i] != ln[i+8]) ok = 1'b0;
      ones8 = 0;
      for (int i = 0; i < 8; i++) ones8 += int'(ln[i]);
      if (ones8 != 6) ok = 1'b0;
      begin
         bit adj = 1'b0;
         for (int i = 0; i < 8; i++)
            if (!ln[i] && !ln[(i+1)%8]) adj = 1'b1;
         if (!adj) ok = 1'b0;
      end
      chk(ok, "R3", "idle line is repeated 0x7E", ones8, 6);
      chk(n_frames == 0 && n_aborts == 0, "R3", "no frame while idle",
          n_frames + n_aborts, 0);

      // R2: empty drops after a write
      exp_lens.push_back(1);
      exp_bytes.push_back(8'hA5);
      put(8'hA5, 1'b1);
      chk(tx_empty == 1'b0, "R2", "empty after write", tx_empty, 0);
      wait_drain();
      chk(tx_empty == 1'b1, "R2", "empty after drain", tx_empty, 1);

      // R6: all-ones payload forces zero insertion, including FCS tail
      begin
         int s0 = n_stuffs;
         exp_lens.push_back(4);
         for (int i = 0; i < 4; i++) begin
            exp_bytes.push_back(8'hFF);
            put(8'hFF, (i == 3));
         end
         wait_drain();
         chk(n_stuffs - s0 >= 6, "R6", "inserted zeros seen", n_stuffs - s0, 6);
      end

      // R4 R5 R6: random messages in back-to-back groups
      for (int g = 0; g < 10; g++) begin
         for (int m = 0; m < 3; m++) send_msg(1 + int'($urandom % 40));
         wait_drain();
      end

      // R2: long message fills the queue
      saw_full = 1'b0;
      send_msg(2 * DEPTH + 4);
      chk(saw_full, "R2", "full seen on long write burst", saw_full, 1);
      wait_drain();

      // R7 R9 R10 R8: underrun with delayed read
      ab0 = n_aborts;
      fr0 = n_frames;
      chk(udr_flag == 1'b0, "R9", "event clear before underrun", udr_flag, 0);
      put(8'h11, 1'b0);
      put(8'h22, 1'b0);
      put(8'h33, 1'b0);
      wait_abort(ok);
      chk(ok, "R7", "underrun raised event", ok, 1);
      chk(tx_bit == 1'b1, "R9", "event aligned with first abort bit", tx_bit, 1);
      ok = 1'b1;
      for (int i = 0; i < 30; i++) begin
         if (!udr_flag) ok = 1'b0;
         @(negedge clk);
      end
      chk(ok, "R9", "event held until read", ok, 1);
      chk(n_aborts == ab0 + 1, "R7", "abort on line", n_aborts - ab0, 1);
      rd_evt = 1'b1;
      chk(udr_flag == 1'b1, "R10", "read returns set", udr_flag, 1);
      @(negedge clk);
      rd_evt = 1'b0;
      chk(udr_flag == 1'b0, "R10", "cleared after read", udr_flag, 0);
      put(8'h44, 1'b0);
      put(8'h55, 1'b1);
      repeat (6) @(negedge clk);
      chk(tx_empty == 1'b1, "R8", "remainder flushed", tx_empty, 1);
      send_msg(5);
      wait_drain();
      chk(n_frames == fr0 + 1, "R8", "only the new frame arrived", n_frames - fr0, 1);

      // R10: read in the same cycle the event is set
      ab0 = n_aborts;
      put(8'hFF, 1'b0);
      put(8'hFF, 1'b0);
      wait_abort(ok);
      chk(ok, "R7", "second underrun raised event", ok, 1);
      rd_evt = 1'b1;
      chk(udr_flag == 1'b1, "R10", "same-cycle read returns set", udr_flag, 1);
      @(negedge clk);
      rd_evt = 1'b0;
      chk(udr_flag == 1'b0, "R10", "same-cycle read clears", udr_flag, 0);
      repeat (20) @(negedge clk);
      chk(udr_flag == 1'b0, "R10", "stays clear", udr_flag, 0);
      chk(n_aborts == ab0 + 1, "R7", "second abort on line", n_aborts - ab0, 1);
      fr0 = n_frames;
      put(8'h7E, 1'b1);
      send_msg(3);
      wait_drain();
      chk(n_frames == fr0 + 1, "R8", "flush then normal frame", n_frames - fr0, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule